// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor

This block gathers a parameterized set of level-sensitive interrupt sources and delivers them to a small group of CPUs. It has two register windows on one simple bus. The global window holds the controller-wide state. The per-CPU window is banked: each access carries a CPU-id input, which selects the bank. Enables and masks are never changed by writing a bit pattern. Software writes a source number to a "set" or "clear" offset instead. This lets several agents change single sources without a read-modify-write.

Sources are split at a fixed boundary. The low-numbered sources (0 up to `LOCAL_LAST`) are private to each CPU. Each CPU has its own mask for them, plus the shared enable. Source 0 is the doorbell summary line. The higher-numbered sources are shared. They are gated by the global enable and by a routing word that holds one bit per CPU. A CPU's interrupt line is raised while at least one eligible source is asserted. Reading the acknowledge offset in that CPU's window returns the lowest eligible source number. When nothing is eligible, the read returns the code 1023.

Top module: `mp_irq_distributor`

## Requirements
- R1: After reset, every enable and routing bit is 0 and every per-CPU mask bit is 1. `cpu_irq` stays 0 and every acknowledge read returns 1023, even with all source inputs high.
- R2: A global write of source number n to offset 0x30 enables source n. A global write of n to offset 0x34 disables it.
- R3: A per-CPU write of n (for n ≤ `LOCAL_LAST`) to offset 0x4C unmasks source n for the CPU given by `bus_cpu`. The same write to offset 0x48 masks it. The masks of the other CPUs do not change.
- R4: The routing word of source n is at global offset 0x100 + 4·n. Bit c of that word routes a shared source to CPU c. The word reads back at the same offset.
- R5: A source numbered ≤ `LOCAL_LAST` (28 by default) ignores its routing word. A source numbered above `LOCAL_LAST` ignores the per-CPU masks.
- R6: A per-CPU read of offset 0x44 returns, in bits [9:0], the lowest source that is eligible for that CPU. The code is 1023 when no source is eligible, and bits [31:10] are 0. Source 0 is returned as 0.
- R7: A global read of offset 0x00 returns `NUM_SRC` in bits [11:2] and 0 in every other bit.
- R8: Sources are level-sensitive. Bit c of `cpu_irq` is a register that shows, one clock later, whether any eligible source for CPU c is asserted. When a source input falls, that source stops being pending.
- R9: The block ignores a number write whose value is out of range. For an enable write, that means ≥ `NUM_SRC`. For a mask write, that means > `LOCAL_LAST`. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cpu | input | CPU_W | CPU id of the access; selects the per-CPU bank |
| bus_win | input | 1 | Window select: 0 global, 1 per-CPU |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wdata | input | DATA_W | Write data (source number or routing word) |
| bus_rdata | output | DATA_W | Read data, 0 when no read is active |
| src_level | input | NUM_SRC | Level inputs of the sources |
| cpu_irq | output | NUM_CPUS | Registered interrupt line per CPU |

## Verification
Two things can change eligibility in the same cycle: a configuration write and a change on a source input. The bench provokes this by raising a source line in the same cycle as the enable or unmask write that admits it. It also drops a source while that source is winning arbitration against a higher-numbered source. In each case the bench waits out the register stage on `cpu_irq`. It then judges both the interrupt line and the acknowledge read against the lowest source that should be eligible.

// File: rtl/mpid_pkg.sv
package mpid_pkg;
   localparam int unsigned OFS_CTRL       = 'h000;
   localparam int unsigned OFS_EN_SET     = 'h030;
   localparam int unsigned OFS_EN_CLR     = 'h034;
   localparam int unsigned OFS_ACK        = 'h044;
   localparam int unsigned OFS_MSK_SET    = 'h048;
   localparam int unsigned OFS_MSK_CLR    = 'h04C;
   localparam int unsigned OFS_ROUTE_BASE = 'h100;
   localparam int unsigned ID_W           = 10;
   localparam logic [ID_W-1:0] IDLE_CODE  = 10'd1023;

   typedef enum logic {
      WIN_GLOBAL = 1'b0,
      WIN_LOCAL  = 1'b1
   } win_e;
endpackage

// File: rtl/mpid_regs.sv
module mpid_regs
   import mpid_pkg::*;
#(
   parameter int NUM_CPUS   = 2,
   parameter int NUM_SRC    = 64,
   parameter int LOCAL_N    = 29,
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int CPU_W      = 1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [CPU_W-1:0]                   bus_cpu,
   input  logic                               bus_win,
   input  logic [ADDR_W-1:0]                  bus_addr,
   input  logic                               bus_wr,
   input  logic [DATA_W-1:0]                  bus_wdata,
   output logic [NUM_SRC-1:0]                 en_o,
   output logic [NUM_CPUS-1:0][LOCAL_N-1:0]   mask_o,
   output logic [NUM_SRC-1:0][NUM_CPUS-1:0]   route_o
);
   logic wr_glb, wr_loc;
   logic hit_en_set, hit_en_clr, hit_msk_set, hit_msk_clr;

   assign wr_glb = bus_wr && (bus_win == WIN_GLOBAL);
   assign wr_loc = bus_wr && (bus_win == WIN_LOCAL);

   assign hit_en_set  = wr_glb && (bus_addr == ADDR_W'(OFS_EN_SET));
   assign hit_en_clr  = wr_glb && (bus_addr == ADDR_W'(OFS_EN_CLR));
   assign hit_msk_set = wr_loc && (bus_addr == ADDR_W'(OFS_MSK_SET));
   assign hit_msk_clr = wr_loc && (bus_addr == ADDR_W'(OFS_MSK_CLR));

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      logic num_hit;
      logic route_hit;
      assign num_hit   = (bus_wdata == DATA_W'(n));
      assign route_hit = wr_glb && (bus_addr == ADDR_W'(OFS_ROUTE_BASE + 4 * n));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_o[n] <= 1'b0;
         end else if (hit_en_set && num_hit) begin
            en_o[n] <= 1'b1;
         end else if (hit_en_clr && num_hit) begin
            en_o[n] <= 1'b0;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            route_o[n] <= '0;
         end else if (route_hit) begin
            route_o[n] <= bus_wdata[NUM_CPUS-1:0];
         end
      end
   end

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      logic cpu_sel;
      assign cpu_sel = (32'(bus_cpu) == c);
      for (genvar n = 0; n < LOCAL_N; n++) begin : g_msk
         logic num_hit;
         assign num_hit = (bus_wdata == DATA_W'(n));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mask_o[c][n] <= 1'b1;
            end else if (cpu_sel && num_hit && hit_msk_set) begin
               mask_o[c][n] <= 1'b1;
            end else if (cpu_sel && num_hit && hit_msk_clr) begin
               mask_o[c][n] <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/mpid_select.sv
module mpid_select
   import mpid_pkg::*;
#(
   parameter int NUM_CPUS = 2,
   parameter int NUM_SRC  = 64,
   parameter int LOCAL_N  = 29
) (
   input  logic [NUM_SRC-1:0]                 src_level,
   input  logic [NUM_SRC-1:0]                 en_i,
   input  logic [NUM_CPUS-1:0][LOCAL_N-1:0]   mask_i,
   input  logic [NUM_SRC-1:0][NUM_CPUS-1:0]   route_i,
   output logic [NUM_CPUS-1:0]                any_o,
   output logic [NUM_CPUS-1:0][ID_W-1:0]      id_o
);
   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      logic [NUM_SRC-1:0] elig;

      for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
         if (n < LOCAL_N) begin : g_local
            assign elig[n] = src_level[n] && en_i[n] && !mask_i[c][n];
         end else begin : g_shared
            assign elig[n] = src_level[n] && en_i[n] && route_i[n][c];
         end
      end

      always_comb begin
         id_o[c]  = IDLE_CODE;
         any_o[c] = 1'b0;
         for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (elig[n]) begin
               id_o[c]  = ID_W'(n);
               any_o[c] = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mpid_rdmux.sv
module mpid_rdmux
   import mpid_pkg::*;
#(
   parameter int NUM_CPUS = 2,
   parameter int NUM_SRC  = 64,
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int CPU_W    = 1
) (
   input  logic                               bus_rd,
   input  logic                               bus_win,
   input  logic [CPU_W-1:0]                   bus_cpu,
   input  logic [ADDR_W-1:0]                  bus_addr,
   input  logic [NUM_SRC-1:0][NUM_CPUS-1:0]   route_i,
   input  logic [NUM_CPUS-1:0][ID_W-1:0]      id_i,
   output logic [DATA_W-1:0]                  rdata_o
);
   localparam logic [DATA_W-1:0] CTRL_WORD = DATA_W'(NUM_SRC) << 2;

   always_comb begin
      rdata_o = '0;
      if (bus_rd) begin
         if (bus_win == WIN_GLOBAL) begin
            if (bus_addr == ADDR_W'(OFS_CTRL)) begin
               rdata_o = CTRL_WORD;
            end
            for (int n = 0; n < NUM_SRC; n++) begin
               if (bus_addr == ADDR_W'(OFS_ROUTE_BASE + 4 * n)) begin
                  rdata_o[NUM_CPUS-1:0] = route_i[n];
               end
            end
         end else if (bus_addr == ADDR_W'(OFS_ACK)) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
               if (32'(bus_cpu) == c) begin
                  rdata_o[ID_W-1:0] = id_i[c];
               end
            end
         end
      end
   end
endmodule

// File: rtl/mp_irq_distributor.sv
module mp_irq_distributor
   import mpid_pkg::*;
#(
   parameter int NUM_CPUS   = 2,
   parameter int NUM_SRC    = 64,
   parameter int LOCAL_LAST = 28,
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   localparam int CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CPU_W-1:0]      bus_cpu,
   input  logic                  bus_win,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NUM_SRC-1:0]    src_level,
   output logic [NUM_CPUS-1:0]   cpu_irq
);
   localparam int LOCAL_N = (LOCAL_LAST + 1 < NUM_SRC) ? LOCAL_LAST + 1 : NUM_SRC;

   if (NUM_CPUS < 1 || NUM_CPUS > 8) begin : g_bad_cpus
      $error("NUM_CPUS must lie in 1..8");
   end
   if (NUM_SRC < 1 || NUM_SRC > 1023) begin : g_bad_src
      $error("NUM_SRC must lie in 1..1023");
   end
   if (LOCAL_LAST < 0) begin : g_bad_local
      $error("LOCAL_LAST must not be negative");
   end
   if (DATA_W < 12) begin : g_bad_data
      $error("DATA_W must hold the control word");
   end
   if (OFS_ROUTE_BASE + 4 * NUM_SRC > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the routing words");
   end

   logic [NUM_SRC-1:0]               en_w;
   logic [NUM_CPUS-1:0][LOCAL_N-1:0] mask_w;
   logic [NUM_SRC-1:0][NUM_CPUS-1:0] route_w;
   logic [NUM_CPUS-1:0]              any_w;
   logic [NUM_CPUS-1:0][ID_W-1:0]    id_w;

   mpid_regs #(
      .NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .LOCAL_N(LOCAL_N),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CPU_W(CPU_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_win(bus_win),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .en_o(en_w), .mask_o(mask_w), .route_o(route_w)
   );

   mpid_select #(
      .NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .LOCAL_N(LOCAL_N)
   ) u_select (
      .src_level(src_level), .en_i(en_w), .mask_i(mask_w),
      .route_i(route_w), .any_o(any_w), .id_o(id_w)
   );

   mpid_rdmux #(
      .NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
      .DATA_W(DATA_W), .CPU_W(CPU_W)
   ) u_rdmux (
      .bus_rd(bus_rd), .bus_win(bus_win), .bus_cpu(bus_cpu),
      .bus_addr(bus_addr), .route_i(route_w), .id_i(id_w),
      .rdata_o(bus_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_irq <= '0;
      end else begin
         cpu_irq <= any_w;
      end
   end
endmodule

// File: rtl/mpid_checker.sv
module mpid_checker #(
   parameter int NUM_CPUS = 2,
   parameter int NUM_SRC  = 64,
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int CPU_W    = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_win,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_rd,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_SRC-1:0]  src_level,
   input logic [NUM_CPUS-1:0] cpu_irq
);
   logic ack_rd, ctrl_rd, hole_rd;
   assign ack_rd  = bus_rd && bus_win && (bus_addr == ADDR_W'('h044));
   assign ctrl_rd = bus_rd && !bus_win && (bus_addr == ADDR_W'('h000));
   assign hole_rd = bus_rd && !bus_win && (bus_addr == ADDR_W'('h008));

   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cpu_irq == '0));

   assert_no_source_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (src_level == '0) |=> (cpu_irq == '0));

   assert_ack_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_rd |-> ((bus_rdata[DATA_W-1:10] == '0) &&
                  ((bus_rdata[9:0] < 10'(NUM_SRC)) || (bus_rdata[9:0] == 10'd1023))));

   assert_ctrl_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rd |-> (bus_rdata == (DATA_W'(NUM_SRC) << 2)));

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hole_rd |-> (bus_rdata == '0));
endmodule

bind mp_irq_distributor mpid_checker #(
   .NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
   .DATA_W(DATA_W), .CPU_W(CPU_W)
) u_mpid_checker (
   .clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_addr(bus_addr),
   .bus_rd(bus_rd), .bus_rdata(bus_rdata), .src_level(src_level),
   .cpu_irq(cpu_irq)
);

// File: tb/test_mp_irq_distributor.sv
module test_mp_irq_distributor;
   localparam int CLK_PERIOD = 10;
   localparam int NCPU = 2;
   localparam int NSRC = 64;

   typedef struct {
      string       req;
      bit          is_irq;
      logic [31:0] exp;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [0:0]  bus_cpu = '0;
   logic        bus_win = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NSRC-1:0] src_level = '0;
   logic [NCPU-1:0] cpu_irq;

   item_t sb_q[$];
   logic  chk_on = 1'b0;
   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mp_irq_distributor i_mp_irq_distributor (
      .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_win(bus_win),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_level(src_level), .cpu_irq(cpu_irq)
   );

   // monitor: pops expected items and compares mid-cycle
   always @(negedge clk) begin
      if (chk_on && sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it  = sb_q.pop_front();
         act = it.is_irq ? 32'(cpu_irq) : bus_rdata;
         n_run++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", it.req, act, it.exp);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wr(bit win, int cpu, int addr, int data);
      bus_win = win; bus_cpu = 1'(cpu); bus_addr = 12'(addr);
      bus_wdata = 32'(data); bus_wr = 1'b1;
      step();
      bus_wr = 1'b0;
   endtask

   task automatic check_rd(string req, bit win, int cpu, int addr, int exp);
      item_t it;
      it.req = req; it.is_irq = 1'b0; it.exp = 32'(exp);
      sb_q.push_back(it);
      bus_win = win; bus_cpu = 1'(cpu); bus_addr = 12'(addr); bus_rd = 1'b1;
      chk_on = 1'b1;
      step();
      bus_rd = 1'b0; chk_on = 1'b0;
   endtask

   task automatic check_irq(string req, int exp);
      item_t it;
      idle(2);
      it.req = req; it.is_irq = 1'b1; it.exp = 32'(exp);
      sb_q.push_back(it);
      chk_on = 1'b1;
      step();
      chk_on = 1'b0;
   endtask

   initial begin
      src_level = '1;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state
      check_irq("R1 irq after reset", 0);
      check_rd("R1 ack cpu0 after reset", 1, 0, 'h44, 1023);
      check_rd("R1 ack cpu1 after reset", 1, 1, 'h44, 1023);
      src_level = '0;
      // R7, R9
      check_rd("R7 control word", 0, 0, 'h000, NSRC << 2);
      check_rd("R9 unmapped global", 0, 0, 'h008, 0);
      check_rd("R9 unmapped local", 1, 0, 'h030, 0);
      // shared source 40 routed to cpu0; source raised with the enable write
      wr(0, 0, 'h1A0, 1);
      src_level[40] = 1'b1;
      wr(0, 0, 'h30, 40);
      check_irq("R2 enable shared 40", 1);
      check_rd("R6 ack cpu0 = 40", 1, 0, 'h44, 40);
      check_rd("R4 cpu1 not routed", 1, 1, 'h44, 1023);
      check_rd("R4 route readback", 0, 0, 'h1A0, 1);
      wr(1, 0, 'h48, 40);
      check_irq("R5 mask ignored for shared", 1);
      wr(0, 0, 'h1A0, 3);
      check_irq("R4 route to both", 3);
      check_rd("R4 ack cpu1 = 40", 1, 1, 'h44, 40);
      wr(0, 0, 'h34, 40);
      check_irq("R2 disable 40", 0);
      // per-CPU source 5
      src_level[5] = 1'b1;
      wr(0, 0, 'h30, 5);
      check_irq("R3 masked after reset", 0);
      wr(1, 1, 'h4C, 5);
      check_irq("R3 unmask cpu1 only", 2);
      check_rd("R3 ack cpu1 = 5", 1, 1, 'h44, 5);
      check_rd("R3 cpu0 still masked", 1, 0, 'h44, 1023);
      wr(0, 0, 'h114, 1);
      check_irq("R5 route ignored for local", 2);
      // priority
      wr(0, 0, 'h30, 40);
      check_irq("R6 both lines", 3);
      check_rd("R6 lowest wins cpu1", 1, 1, 'h44, 5);
      check_rd("R6 cpu0 gets 40", 1, 0, 'h44, 40);
      // level behaviour
      src_level[5] = 1'b0;
      idle(1);
      check_rd("R8 drop 5, cpu1 gets 40", 1, 1, 'h44, 40);
      src_level[40] = 1'b0;
      check_irq("R8 all dropped", 0);
      check_rd("R8 cpu0 idle code", 1, 0, 'h44, 1023);
      // out-of-range numbers
      wr(0, 0, 'h34, 5);
      src_level[5] = 1'b1;
      wr(0, 0, 'h30, 69);
      check_irq("R9 enable 69 ignored", 0);
      wr(0, 0, 'h30, 5);
      check_irq("R2 enable 5 again", 2);
      wr(1, 1, 'h48, 69);
      check_irq("R9 mask 69 ignored", 2);
      wr(1, 1, 'h48, 5);
      check_irq("R3 mask cpu1 5", 0);
      src_level[5] = 1'b0;
      // boundary 28 / 29
      src_level[28] = 1'b1; src_level[29] = 1'b1;
      wr(0, 0, 'h170, 3);
      wr(0, 0, 'h174, 2);
      wr(0, 0, 'h30, 28);
      wr(0, 0, 'h30, 29);
      check_irq("R5 28 masked, 29 routed cpu1", 2);
      check_rd("R5 ack cpu1 = 29", 1, 1, 'h44, 29);
      wr(1, 0, 'h4C, 28);
      check_irq("R5 unmask 28 cpu0", 3);
      check_rd("R5 ack cpu0 = 28", 1, 0, 'h44, 28);
      wr(1, 1, 'h4C, 28);
      check_rd("R6 cpu1 prefers 28", 1, 1, 'h44, 28);
      // doorbell summary source 0
      src_level[0] = 1'b1;
      wr(0, 0, 'h30, 0);
      wr(1, 0, 'h4C, 0);
      idle(1);
      check_rd("R6 ack cpu0 = 0", 1, 0, 'h44, 0);
      check_rd("R6 cpu1 keeps 28", 1, 1, 'h44, 28);
      idle(2);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule